// File: doc/BRIEF.md
# Bidirectional Two-Bus Shift Register

This block keeps an eight-stage data register between two parallel buses, named A and B, and adds a serial data input. A direction control picks which bus feeds the register and which bus shows its contents. A mode control picks between a parallel load of all stages from the feeding bus and a one-position serial shift. In parallel mode, a timing control picks between loading once on each register-clock rising edge and following the feeding bus on every system-clock cycle.

An enable on the A side decides two things: whether A is taken as parallel input, and whether the A drivers leave high impedance. When the feeding bus is blocked, the register keeps its value, so the block also works as a store. Serial shifting moves data from stage 0 toward the last stage. The last stage appears on a serial output so that several blocks can be chained. Each bus is modelled as separate input, output and output-enable ports. The register clock is a slow strobe that is sampled on the single system clock.

Top module: `bidir_bus_shreg`

## Requirements
- R1: A system-clock edge with `rst_n` low clears every stage to zero. One cycle later, `b_out`, `a_out` and `ser_out` read 0.
- R2: With `dir_b2a`=0, `par_mode`=1, `imm_load`=0 and `a_en`=1, a rising edge on `shift_clk` loads `a_in` into the register. The new value is visible one system clock after the edge is sampled.
- R3: With `dir_b2a`=1 and `par_mode`=1, the register loads from `b_in` on the same timing as R2. `a_en` has no effect on this load.
- R4: In clocked parallel mode (`imm_load`=0) and in serial mode (`par_mode`=0), the register does not change on a system clock where `shift_clk` has no rising edge.
- R5: With `par_mode`=1 and `imm_load`=1, the register takes the feeding bus on every system-clock cycle, without any `shift_clk` edge. The feeding bus is A when `dir_b2a`=0 and `a_en`=1, and B when `dir_b2a`=1.
- R6: With `dir_b2a`=0, `par_mode`=1 and `a_en`=0, the register holds its value in both load timings and through `shift_clk` edges.
- R7: With `par_mode`=0, each `shift_clk` rising edge moves stage i into stage i+1 and loads `ser_in` into stage 0. `a_en` has no effect on shifting. `ser_out` always equals the last stage (bit 7).
- R8: `b_out` always shows the register contents. `b_oe` is 1 exactly when `dir_b2a`=0.
- R9: `a_out` always shows the register contents. `a_oe` is 1 exactly when `dir_b2a`=1 and `a_en`=1. Otherwise A is in high impedance.
- R10: Only a low-to-high change of `shift_clk` counts as an edge. Holding `shift_clk` high for several system clocks gives exactly one load or shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| shift_clk | input | 1 | Register clock, sampled for rising edges |
| dir_b2a | input | 1 | 0: A feeds, B shows; 1: B feeds, A shows |
| par_mode | input | 1 | 1: parallel load; 0: serial shift |
| imm_load | input | 1 | 1: follow the feeding bus every cycle in parallel mode |
| a_en | input | 1 | A-side enable for input acceptance and output drive |
| ser_in | input | 1 | Serial data into stage 0 |
| a_in | input | 8 | A bus input lines |
| b_in | input | 8 | B bus input lines |
| a_out | output | 8 | A bus output lines |
| a_oe | output | 1 | A bus drive enable |
| b_out | output | 8 | B bus output lines |
| b_oe | output | 1 | B bus drive enable |
| ser_out | output | 1 | Last stage, used for chaining |

## Verification
The assertions check these rules on every cycle:
- the clear after reset;
- the register staying stable when no edge arrives in clocked or serial mode, and when the A bus is blocked;
- the one-cycle tracking in immediate mode;
- the shift relation from `ser_in` onward;
- the rule that at most one bus drives at any time.

Only the bench scenarios can show the following, by comparing every cycle against a reference model under random and directed control mixes:
- that a `shift_clk` held high gives a single event;
- that a whole byte moved through eight shifts comes out unchanged on either bus;
- that loads in both directions pick the correct bus.

// File: rtl/bsr_pkg.sv
// Package: shared types for the bidirectional two-bus shift register.
// Assumes: nothing beyond IEEE 1800-2017.
package bsr_pkg;

    // What the stage array does on the next system-clock edge.
    typedef enum logic [1:0] {
        BSR_HOLD  = 2'd0,
        BSR_LOAD  = 2'd1,
        BSR_SHIFT = 2'd2
    } bsr_op_e;

endpackage

// File: rtl/bsr_strobe.sv
// Module: bsr_strobe
// Turns the slow register clock into a one-cycle strobe on its rising edge.
// Assumes: shift_clk is already synchronous to clk; the sampled level is
// cleared by reset, so a high level right after reset counts as an edge.
module bsr_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic shift_clk,
    output logic rise
);

    logic level_q;

    // Keep the level seen on the previous system clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= 1'b0;
        end else begin
            level_q <= shift_clk;
        end
    end

    // Strobe is high for one cycle after a low-to-high change.
    always_comb begin
        rise = shift_clk & ~level_q;
    end

endmodule

// File: rtl/bsr_ctrl.sv
// Module: bsr_ctrl
// Picks the feeding bus and decides between hold, load and shift.
// Assumes: the B bus always accepts input when it feeds; A only when a_en.
module bsr_ctrl
    import bsr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             dir_b2a,
    input  logic             par_mode,
    input  logic             imm_load,
    input  logic             a_en,
    input  logic             rise,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    output bsr_op_e          op,
    output logic [WIDTH-1:0] load_data
);

    logic src_ok;
    logic load_time;

    // Select the feeding bus and whether it is accepted.
    always_comb begin
        if (dir_b2a) begin
            load_data = b_in;
            src_ok    = 1'b1;
        end else begin
            load_data = a_in;
            src_ok    = a_en;
        end
    end

    // Immediate timing loads every cycle, clocked timing only on the strobe.
    always_comb begin
        load_time = imm_load | rise;
    end

    // Final operation code for the stage array.
    always_comb begin
        op = BSR_HOLD;
        if (par_mode) begin
            if (src_ok && load_time) begin
                op = BSR_LOAD;
            end
        end else if (rise) begin
            op = BSR_SHIFT;
        end
    end

endmodule

// File: rtl/bsr_stages.sv
// Module: bsr_stages
// The register itself: one flip-flop per stage, built with generate.
// Assumes: shifting moves stage i into stage i+1, serial data enters stage 0.
module bsr_stages
    import bsr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  bsr_op_e          op,
    input  logic [WIDTH-1:0] load_data,
    input  logic             ser_in,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] shift_src;

    // Value each stage takes on a shift.
    always_comb begin
        shift_src = {q[WIDTH-2:0], ser_in};
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        // Update one stage according to the operation code.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q[i] <= 1'b0;
            end else begin
                case (op)
                    BSR_LOAD:  q[i] <= load_data[i];
                    BSR_SHIFT: q[i] <= shift_src[i];
                    default:   q[i] <= q[i];
                endcase
            end
        end
    end

endmodule

// File: rtl/bsr_bus_io.sv
// Module: bsr_bus_io
// Drives both buses and the serial output from the register contents.
// Assumes: tristate buffers outside the block use the *_oe outputs.
module bsr_bus_io #(
    parameter int WIDTH = 8
) (
    input  logic             dir_b2a,
    input  logic             a_en,
    input  logic [WIDTH-1:0] q,
    output logic [WIDTH-1:0] a_out,
    output logic             a_oe,
    output logic [WIDTH-1:0] b_out,
    output logic             b_oe,
    output logic             ser_out
);

    // Data lines always carry the contents; the enables decide who drives.
    always_comb begin
        a_out   = q;
        b_out   = q;
        ser_out = q[WIDTH-1];
    end

    // A drives only toward A when enabled; B drives whenever it is the destination.
    always_comb begin
        a_oe = dir_b2a & a_en;
        b_oe = ~dir_b2a;
    end

endmodule

// File: rtl/bidir_bus_shreg.sv
// Module: bidir_bus_shreg (top)
// Register between two parallel buses with serial shift and selectable
// immediate or clocked parallel load.
// Assumes: one system clock; shift_clk is synchronous and slower than clk.
module bidir_bus_shreg
    import bsr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_clk,
    input  logic             dir_b2a,
    input  logic             par_mode,
    input  logic             imm_load,
    input  logic             a_en,
    input  logic             ser_in,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] a_out,
    output logic             a_oe,
    output logic [WIDTH-1:0] b_out,
    output logic             b_oe,
    output logic             ser_out
);

    logic             rise;
    bsr_op_e          op;
    logic [WIDTH-1:0] load_data;
    logic [WIDTH-1:0] q;

    bsr_strobe u_strobe (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_clk (shift_clk),
        .rise      (rise)
    );

    bsr_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .dir_b2a   (dir_b2a),
        .par_mode  (par_mode),
        .imm_load  (imm_load),
        .a_en      (a_en),
        .rise      (rise),
        .a_in      (a_in),
        .b_in      (b_in),
        .op        (op),
        .load_data (load_data)
    );

    bsr_stages #(.WIDTH(WIDTH)) u_stages (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op),
        .load_data (load_data),
        .ser_in    (ser_in),
        .q         (q)
    );

    bsr_bus_io #(.WIDTH(WIDTH)) u_io (
        .dir_b2a (dir_b2a),
        .a_en    (a_en),
        .q       (q),
        .a_out   (a_out),
        .a_oe    (a_oe),
        .b_out   (b_out),
        .b_oe    (b_oe),
        .ser_out (ser_out)
    );

endmodule

// File: rtl/bsr_chk.sv
// Module: bsr_chk
// Port-level checker for bidir_bus_shreg, attached with bind below.
// Assumes: only top-level ports are visible; edge history is rebuilt here.
module bsr_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             shift_clk,
    input logic             dir_b2a,
    input logic             par_mode,
    input logic             imm_load,
    input logic             a_en,
    input logic             ser_in,
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] b_in,
    input logic [WIDTH-1:0] a_out,
    input logic             a_oe,
    input logic [WIDTH-1:0] b_out,
    input logic             b_oe,
    input logic             ser_out
);

    logic             sclk_q;
    logic             sclk_up;
    logic             feed_ok;
    logic [WIDTH-1:0] feed;

    // Track the register clock level independently of the design.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= shift_clk;
    end

    // Edge and feeding-bus views derived from ports.
    always_comb begin
        sclk_up = shift_clk & ~sclk_q;
        feed_ok = dir_b2a | a_en;
        feed    = dir_b2a ? b_in : a_in;
    end

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (b_out == '0 && a_out == '0 && ser_out == 1'b0));

    // R4
    no_edge_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sclk_up && !(par_mode && imm_load)) |=> $stable(b_out));

    // R5
    imm_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (par_mode && imm_load && feed_ok) |=> (b_out == $past(feed)));

    // R6
    blocked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (par_mode && !dir_b2a && !a_en) |=> $stable(b_out));

    // R7
    shift_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!par_mode && sclk_up) |=> (b_out == {$past(b_out[WIDTH-2:0]), $past(ser_in)}));

    // R7
    ser_tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ser_out == b_out[WIDTH-1]);

    // R9
    a_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        a_oe |-> (dir_b2a && a_en && a_out == b_out));

    // R8
    one_driver_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({a_oe, b_oe}));

endmodule

bind bidir_bus_shreg bsr_chk #(.WIDTH(WIDTH)) u_bsr_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_clk (shift_clk),
    .dir_b2a   (dir_b2a),
    .par_mode  (par_mode),
    .imm_load  (imm_load),
    .a_en      (a_en),
    .ser_in    (ser_in),
    .a_in      (a_in),
    .b_in      (b_in),
    .a_out     (a_out),
    .a_oe      (a_oe),
    .b_out     (b_out),
    .b_oe      (b_oe),
    .ser_out   (ser_out)
);

// File: tb/tb_bidir_bus_shreg.sv
`timescale 1ns/1ps
module tb_bidir_bus_shreg;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       shift_clk = 1'b0;
    logic       dir_b2a = 1'b0;
    logic       par_mode = 1'b0;
    logic       imm_load = 1'b0;
    logic       a_en = 1'b0;
    logic       ser_in = 1'b0;
    logic [7:0] a_in = 8'h00;
    logic [7:0] b_in = 8'h00;
    logic [7:0] a_out;
    logic       a_oe;
    logic [7:0] b_out;
    logic       b_oe;
    logic       ser_out;

    int   n_chk = 0;
    int   n_err = 0;
    bit   done = 1'b0;
    logic [7:0] exp_q = 8'h00;
    logic       prev_sc = 1'b0;

    always #2 clk = ~clk;

    bidir_bus_shreg dut (
        .clk(clk), .rst_n(rst_n), .shift_clk(shift_clk), .dir_b2a(dir_b2a),
        .par_mode(par_mode), .imm_load(imm_load), .a_en(a_en), .ser_in(ser_in),
        .a_in(a_in), .b_in(b_in), .a_out(a_out), .a_oe(a_oe), .b_out(b_out),
        .b_oe(b_oe), .ser_out(ser_out)
    );

    // Reference next value, from R1..R7 and R10.
    function automatic logic [7:0] ref_next(input logic [7:0] cur, input logic rst,
        input logic rise, input logic d, input logic p, input logic im,
        input logic en, input logic si, input logic [7:0] ai, input logic [7:0] bi);
        if (!rst) return 8'h00;
        if (p) begin
            if ((d || en) && (im || rise)) return d ? bi : ai;
            return cur;
        end
        if (rise) return {cur[6:0], si};
        return cur;
    endfunction

    // Requirement tag naming the operation just modelled.
    function automatic string tag_of(input logic rst, input logic rise, input logic d,
        input logic p, input logic im, input logic en);
        if (!rst) return "R1";
        if (p && !d && !en) return "R6";
        if (p && im) return "R5";
        if (p && rise) return d ? "R3" : "R2";
        if (!p && rise) return "R7";
        return "R4/R10";
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One system cycle: drive, model the edge, compare after it.
    task automatic step(input logic rst, input logic sc, input logic d, input logic p,
        input logic im, input logic en, input logic si, input logic [7:0] ai,
        input logic [7:0] bi);
        logic  rise;
        string t;
        rst_n = rst; shift_clk = sc; dir_b2a = d; par_mode = p;
        imm_load = im; a_en = en; ser_in = si; a_in = ai; b_in = bi;
        @(posedge clk);
        rise    = sc & ~prev_sc;
        t       = tag_of(rst, rise, d, p, im, en);
        exp_q   = ref_next(exp_q, rst, rise, d, p, im, en, si, ai, bi);
        prev_sc = rst ? sc : 1'b0;
        @(negedge clk);
        check(b_out == exp_q, t, "b_out", b_out, exp_q);
        check(a_out == exp_q, "R9", "a_out", a_out, exp_q);
        check(ser_out == exp_q[7], "R7", "ser_out", {7'd0, ser_out}, {7'd0, exp_q[7]});
        check(b_oe == !d, "R8", "b_oe", {7'd0, b_oe}, {7'd0, !d});
        check(a_oe == (d && en), "R9", "a_oe", {7'd0, a_oe}, {7'd0, d && en});
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] pat;
        void'($urandom(32'd20240611));
        @(negedge clk);
        // R1: reset clears
        step(0, 0, 0, 1, 1, 1, 1, 8'hFF, 8'hFF);
        step(0, 0, 0, 1, 1, 1, 1, 8'hFF, 8'hFF);
        // R2: clocked load A to B
        step(1, 0, 0, 1, 0, 1, 0, 8'h5A, 8'h00);
        step(1, 1, 0, 1, 0, 1, 0, 8'h5A, 8'h00);
        // R10: held high, new A value ignored
        step(1, 1, 0, 1, 0, 1, 0, 8'hC3, 8'h00);
        step(1, 1, 0, 1, 0, 1, 0, 8'h99, 8'h00);
        // R6: A blocked, edge and immediate both ignored
        step(1, 0, 0, 1, 0, 0, 0, 8'h11, 8'h00);
        step(1, 1, 0, 1, 0, 0, 0, 8'h22, 8'h00);
        step(1, 1, 0, 1, 1, 0, 0, 8'h33, 8'h00);
        // R3: B to A load with a_en low, then A driving with a_en high (R9)
        step(1, 0, 1, 1, 0, 0, 0, 8'h00, 8'hA7);
        step(1, 1, 1, 1, 0, 0, 0, 8'h00, 8'hA7);
        step(1, 1, 1, 1, 0, 1, 0, 8'h00, 8'h3C);
        // R5: immediate load follows B each cycle without edges
        step(1, 0, 1, 1, 1, 1, 0, 8'h00, 8'h01);
        step(1, 0, 1, 1, 1, 1, 0, 8'h00, 8'h80);
        step(1, 0, 0, 1, 1, 1, 0, 8'h6E, 8'h00);
        // R7: eight serial shifts with a_en low, byte lands intact
        pat = 8'hB5;
        for (int i = 7; i >= 0; i--) begin
            step(1, 0, 0, 0, 0, 0, pat[i], 8'hFF, 8'hFF);
            step(1, 1, 0, 0, 0, 0, pat[i], 8'hFF, 8'hFF);
        end
        check(b_out == pat, "R7", "byte after 8 shifts", b_out, pat);
        // R4: serial mode, no edge
        step(1, 1, 1, 0, 0, 1, 1, 8'hFF, 8'hFF);
        step(1, 0, 1, 0, 0, 1, 1, 8'hFF, 8'hFF);
        // Random mix
        for (int k = 0; k < 600; k++) begin
            step(($urandom % 40) != 0, $urandom % 2, $urandom % 2, $urandom % 2,
                 ($urandom % 4) == 0, $urandom % 2, $urandom % 2,
                 8'($urandom), 8'($urandom));
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule